// File: doc/BRIEF.md
# Serial Byte-to-Word Packing Engine

This block sits between a byte-wide serial shifter and a 32-bit bus data register. On the receive side it collects characters from the shifter into 32-bit words. On the transmit side it breaks 32-bit words written by the bus into a byte stream for the shifter. Word mode can be switched on separately for each direction. When a direction is in byte mode, each character passes on its own in the lowest byte lane.

Characters are at most 8 bits wide. Each character keeps its own 8-bit lane, and bits above the character size are forced to zero. Event flags fire once per word: `rx_done` on the receive side and `tx_empty` on the transmit side. A frame length counter can be applied to one direction at a time. Once the counted frame reaches its programmed length, the final flag fires on the last byte, even when that byte leaves the word partly filled.

Receive FSM states: RX_B0, RX_B1, RX_B2 and RX_B3 give the lane the next received byte goes into. A word-mode byte moves the FSM to the next lane. A byte in RX_B3, or a byte that ends the counted frame, closes the word and returns the FSM to RX_B0. Byte mode leaves the state unchanged.

Transmit FSM states: TX_IDLE means no word is held. TX_L0, TX_L1, TX_L2 and TX_L3 give the lane currently offered to the shifter. A load in TX_IDLE moves the FSM to TX_L0. A take advances the FSM one lane. A take returns the FSM to TX_IDLE in three cases: in byte mode, in TX_L3, or on the last byte of a counted frame.

Top module: `byte_word_packer`

## Requirements
- R1: After reset, `rx_done`, `tx_empty` and `tx_byte_valid` are 0, and `rx_word` is all zero.
- R2: In receive word mode, four received bytes form one word. The first byte goes to bits 7:0 and the fourth byte to bits 31:24. `rx_done` pulses for one cycle, in the cycle after the fourth byte is sampled.
- R3: In receive byte mode, every received byte raises `rx_done` in the next cycle. The byte appears in bits 7:0 and bits 31:8 are zero.
- R4: `char_size` values 1 to 7 give that many valid bits per character; any other value means 8 bits. In every received byte lane, bits at or above the character size read as zero.
- R5: In transmit word mode, a loaded word is offered as bits 7:0, then 15:8, then 23:16, then 31:24, one lane per take. `tx_empty` pulses in the cycle after the fourth take, and `tx_byte_valid` is then 0.
- R6: In transmit byte mode, only bits 7:0 of a loaded word are offered. `tx_empty` pulses in the cycle after that single take.
- R7: On transmit, bits of the offered byte at or above the character size are output as zero.
- R8: With `len_sel` equal to 1, received bytes are counted. The byte that reaches `len_total` closes the word at once: `rx_done` pulses and the unfilled upper lanes read as zero.
- R9: With `len_sel` equal to 2, transmitted bytes are counted. The take that reaches `len_total` ends the word: `tx_empty` pulses and the remaining lanes are not offered.
- R10: The length count restarts from zero when it reaches `len_total`, and in any cycle in which `len_sel` is 0.
- R11: Without the length counter, a receive word holding fewer than four bytes raises no `rx_done`.
- R12: Word mode and the length counter apply only to their own direction. A count selected for one direction never ends a word in the other direction.
- R13: A load while a transmit word is still being drained is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_word_en | input | 1 | Receive word mode |
| tx_word_en | input | 1 | Transmit word mode |
| char_size | input | 4 | Character width, 1..7; other values mean 8 |
| len_sel | input | 2 | 0 off, 1 count receive, 2 count transmit, 3 off |
| len_total | input | 8 | Frame length in characters, 1..255 |
| rx_byte_valid | input | 1 | Shifter delivers a received character |
| rx_byte | input | 8 | Received character |
| rx_word | output | 32 | Last completed receive word |
| rx_done | output | 1 | Receive-complete event pulse |
| tx_load | input | 1 | Bus writes a transmit word |
| tx_word | input | 32 | Transmit word |
| tx_take | input | 1 | Shifter accepts the offered byte |
| tx_byte_valid | output | 1 | A transmit byte is on offer |
| tx_byte | output | 8 | Offered transmit byte |
| tx_empty | output | 1 | Data-empty event pulse |

## Verification
`rx_word` and `rx_done` come from registers. They change one cycle after the edge that samples the closing byte. The offered transmit byte is decoded from the transmit state, so it becomes valid in the cycle after a load and moves to the next lane in the cycle after each take. `tx_empty` follows the closing take by one cycle. The bench drives inputs just after the falling edge and advances its reference model on the rising edge. It compares every output at the next falling edge, so each expectation is read in exactly the cycle these latencies give.

// File: rtl/bwp_pkg.sv
package bwp_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = 4;
    localparam int unsigned WORD_W = BYTE_W * LANES;

    // length counter direction select
    typedef enum logic [1:0] {
        LEN_OFF  = 2'd0,
        LEN_RX   = 2'd1,
        LEN_TX   = 2'd2,
        LEN_RSVD = 2'd3
    } len_sel_e;

    // receive: lane the next byte lands in
    typedef enum logic [1:0] {
        RX_B0 = 2'd0,
        RX_B1 = 2'd1,
        RX_B2 = 2'd2,
        RX_B3 = 2'd3
    } rx_state_e;

    // transmit: idle or lane on offer
    typedef enum logic [2:0] {
        TX_IDLE = 3'd0,
        TX_L0   = 3'd1,
        TX_L1   = 3'd2,
        TX_L2   = 3'd3,
        TX_L3   = 3'd4
    } tx_state_e;

    // valid-bit mask for one character lane
    function automatic logic [BYTE_W-1:0] char_mask(input logic [3:0] size);
        logic [BYTE_W:0] wide;
        wide = '1;
        if (size >= 4'd1 && size < 4'(BYTE_W)) begin
            wide = (9'd1 << size) - 9'd1;
        end
        return wide[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/bwp_len_counter.sv
module bwp_len_counter
    import bwp_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel,
    input  logic [LEN_W-1:0] total,
    input  logic             rx_event,
    input  logic             tx_event,
    output logic             rx_last,
    output logic             tx_last
);

    len_sel_e         mode;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W:0]   cnt_inc;
    logic             ev;
    logic             reach;

    assign mode    = len_sel_e'(sel);
    assign cnt_inc = {1'b0, cnt_q} + {{LEN_W{1'b0}}, 1'b1};

    always_comb begin : pick_event
        ev = 1'b0;
        unique case (mode)
            LEN_RX:   ev = rx_event;
            LEN_TX:   ev = tx_event;
            LEN_OFF:  ev = 1'b0;
            LEN_RSVD: ev = 1'b0;
        endcase
    end

    assign reach   = ev && (cnt_inc == {1'b0, total});
    assign rx_last = reach && (mode == LEN_RX);
    assign tx_last = reach && (mode == LEN_TX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (mode == LEN_OFF) begin
            cnt_q <= '0;
        end else if (reach) begin
            cnt_q <= '0;
        end else if (ev) begin
            cnt_q <= cnt_inc[LEN_W-1:0];
        end
    end

    AST_LEN_CLEAR_ON_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LEN_OFF) |=> (cnt_q == '0)); // R10
    AST_LEN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_last || tx_last) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/bwp_rx_pack.sv
module bwp_rx_pack
    import bwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_en,
    input  logic [3:0]        char_size,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              last_in,
    output logic [WORD_W-1:0] word_out,
    output logic              done
);

    rx_state_e         state_q, state_d;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic              done_q;
    logic [BYTE_W-1:0] lane_val;
    logic [1:0]        lane;
    logic              close_word;

    assign lane_val   = byte_in & char_mask(char_size);
    assign lane       = state_q;
    assign close_word = (state_q == RX_B3) || last_in;

    always_comb begin : merge_lane
        merged = acc_q;
        merged[lane*BYTE_W +: BYTE_W] = lane_val;
    end

    // next state
    always_comb begin : rx_next
        state_d = state_q;
        if (byte_valid && word_en) begin
            if (close_word) begin
                state_d = RX_B0;
            end else begin
                unique case (state_q)
                    RX_B0: state_d = RX_B1;
                    RX_B1: state_d = RX_B2;
                    RX_B2: state_d = RX_B3;
                    RX_B3: state_d = RX_B0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin : rx_state_reg
        if (!rst_n) state_q <= RX_B0;
        else        state_q <= state_d;
    end

    // outputs and word accumulator
    always_ff @(posedge clk or negedge rst_n) begin : rx_out_reg
        if (!rst_n) begin
            acc_q  <= '0;
            word_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (byte_valid) begin
                if (!word_en) begin
                    word_q <= {{(WORD_W-BYTE_W){1'b0}}, lane_val};
                    done_q <= 1'b1;
                end else if (close_word) begin
                    word_q <= merged;
                    done_q <= 1'b1;
                    acc_q  <= '0;
                end else begin
                    acc_q  <= merged;
                end
            end
        end
    end

    assign word_out = word_q;
    assign done     = done_q;

    AST_RX_DONE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(byte_valid)); // R2
    AST_RX_BYTE_MODE_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && !word_en) |=> (done_q && (word_q[WORD_W-1:BYTE_W] == '0))); // R3
    AST_RX_LANE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && $stable(char_size)) |-> ((word_q & ~{LANES{char_mask(char_size)}}) == '0)); // R4
    AST_RX_PARTIAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_valid && word_en && state_q != RX_B3 && !last_in) |=> !done_q); // R11

endmodule

// File: rtl/bwp_tx_split.sv
module bwp_tx_split
    import bwp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_en,
    input  logic [3:0]        char_size,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              take,
    input  logic              last_in,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_out,
    output logic              empty
);

    tx_state_e         state_q, state_d;
    logic [WORD_W-1:0] word_q;
    logic              empty_q;
    logic [1:0]        lane;
    logic              busy;
    logic              fire;
    logic              close_word;

    assign busy       = (state_q != TX_IDLE);
    assign fire       = take && busy;
    assign close_word = !word_en || (state_q == TX_L3) || last_in;

    always_comb begin : lane_decode
        lane = 2'd0;
        unique case (state_q)
            TX_IDLE: lane = 2'd0;
            TX_L0:   lane = 2'd0;
            TX_L1:   lane = 2'd1;
            TX_L2:   lane = 2'd2;
            TX_L3:   lane = 2'd3;
            default: lane = 2'd0;
        endcase
    end

    // next state
    always_comb begin : tx_next
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)       state_d = TX_L0;
            TX_L0:   if (fire)       state_d = close_word ? TX_IDLE : TX_L1;
            TX_L1:   if (fire)       state_d = close_word ? TX_IDLE : TX_L2;
            TX_L2:   if (fire)       state_d = close_word ? TX_IDLE : TX_L3;
            TX_L3:   if (fire)       state_d = TX_IDLE;
            default:                 state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : tx_state_reg
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // held word and data-empty event
    always_ff @(posedge clk or negedge rst_n) begin : tx_out_reg
        if (!rst_n) begin
            word_q  <= '0;
            empty_q <= 1'b0;
        end else begin
            empty_q <= fire && close_word;
            if (!busy && load) begin
                word_q <= word_in;
            end
        end
    end

    assign byte_valid = busy;
    assign byte_out   = word_q[lane*BYTE_W +: BYTE_W] & char_mask(char_size);
    assign empty      = empty_q;

    AST_TX_EMPTY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        empty_q |-> ($past(take) && !byte_valid)); // R5
    AST_TX_BYTE_MODE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !word_en) |=> (empty_q && !byte_valid)); // R6
    AST_TX_BUSY_KEEPS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> $stable(word_q)); // R13

endmodule

// File: rtl/byte_word_packer.sv
module byte_word_packer
    import bwp_pkg::*;
#(
    parameter int unsigned LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_word_en,
    input  logic              tx_word_en,
    input  logic [3:0]        char_size,
    input  logic [1:0]        len_sel,
    input  logic [LEN_W-1:0]  len_total,
    input  logic              rx_byte_valid,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_done,
    input  logic              tx_load,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              tx_take,
    output logic              tx_byte_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_empty
);

    logic rx_last;
    logic tx_last;
    logic rx_count_ev;
    logic tx_count_ev;

    assign rx_count_ev = rx_byte_valid && rx_word_en;
    assign tx_count_ev = tx_take && tx_byte_valid && tx_word_en;

    bwp_len_counter #(.LEN_W(LEN_W)) u_len (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (len_sel),
        .total    (len_total),
        .rx_event (rx_count_ev),
        .tx_event (tx_count_ev),
        .rx_last  (rx_last),
        .tx_last  (tx_last)
    );

    bwp_rx_pack u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_en    (rx_word_en),
        .char_size  (char_size),
        .byte_valid (rx_byte_valid),
        .byte_in    (rx_byte),
        .last_in    (rx_last),
        .word_out   (rx_word),
        .done       (rx_done)
    );

    bwp_tx_split u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_en    (tx_word_en),
        .char_size  (char_size),
        .load       (tx_load),
        .word_in    (tx_word),
        .take       (tx_take),
        .last_in    (tx_last),
        .byte_valid (tx_byte_valid),
        .byte_out   (tx_byte),
        .empty      (tx_empty)
    );

    AST_DIR_SEPARATE: assert property (@(posedge clk) disable iff (!rst_n)
        (len_sel == 2'd1 && !rx_byte_valid) |=> !rx_done); // R12

endmodule

// File: tb/sim_byte_word_packer.sv
`timescale 1ns/1ps
module sim_byte_word_packer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_word_en = 1'b0, tx_word_en = 1'b0;
    logic [3:0]  char_size = 4'd8;
    logic [1:0]  len_sel = 2'd0;
    logic [7:0]  len_total = 8'd0;
    logic        rx_byte_valid = 1'b0;
    logic [7:0]  rx_byte = 8'd0;
    logic [31:0] rx_word;
    logic        rx_done;
    logic        tx_load = 1'b0;
    logic [31:0] tx_word = 32'd0;
    logic        tx_take = 1'b0;
    logic        tx_byte_valid;
    logic [7:0]  tx_byte;
    logic        tx_empty;

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    byte_word_packer u0 (.*);

    function automatic int msk(input int cs);
        if (cs >= 1 && cs <= 7) return (1 << cs) - 1;
        return 255;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    int          m_lane = 0, m_cnt = 0, t_lane = -1;
    logic [31:0] m_acc = 0, t_word = 0, e_rx_word = 0;
    bit          e_rx_done = 0, e_empty = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lane = 0; m_cnt = 0; t_lane = -1; m_acc = 0; t_word = 0;
            e_rx_word = 0; e_rx_done = 0; e_empty = 0;
        end else begin
            bit ev_rx, ev_tx, lst;
            int b;
            e_rx_done = 0; e_empty = 0;
            ev_rx = rx_byte_valid && rx_word_en && len_sel == 2'd1;
            ev_tx = tx_take && t_lane >= 0 && tx_word_en && len_sel == 2'd2;
            lst   = (ev_rx || ev_tx) && (m_cnt + 1 == int'(len_total));
            if (rx_byte_valid) begin
                b = int'(rx_byte) & msk(int'(char_size));
                if (!rx_word_en) begin
                    e_rx_word = b; e_rx_done = 1;
                end else begin
                    m_acc[8*m_lane +: 8] = b[7:0];
                    if (m_lane == 3 || (lst && ev_rx)) begin
                        e_rx_word = m_acc; e_rx_done = 1; m_acc = 0; m_lane = 0;
                    end else m_lane++;
                end
            end
            if (t_lane < 0) begin
                if (tx_load) begin t_word = tx_word; t_lane = 0; end
            end else if (tx_take) begin
                if (!tx_word_en || t_lane == 3 || (lst && ev_tx)) begin
                    t_lane = -1; e_empty = 1;
                end else t_lane++;
            end
            if (len_sel == 2'd0) m_cnt = 0;
            else if (ev_rx || ev_tx) m_cnt = lst ? 0 : m_cnt + 1;
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rx_done == e_rx_done, cur_tag, "rx_done", 32'(rx_done), 32'(e_rx_done));
            chk(rx_word == e_rx_word, cur_tag, "rx_word", rx_word, e_rx_word);
            chk(tx_empty == e_empty, cur_tag, "tx_empty", 32'(tx_empty), 32'(e_empty));
            chk(tx_byte_valid == (t_lane >= 0), cur_tag, "tx_byte_valid",
                32'(tx_byte_valid), 32'(t_lane >= 0));
            if (t_lane >= 0)
                chk(int'(tx_byte) == (int'(t_word >> (8*t_lane)) & msk(int'(char_size))),
                    cur_tag, "tx_byte", 32'(tx_byte),
                    32'(int'(t_word >> (8*t_lane)) & msk(int'(char_size))));
        end
    end

    task automatic cyc();
        @(posedge clk); @(negedge clk); #1;
    endtask
    task automatic send_rx(input logic [7:0] v);
        rx_byte_valid = 1'b1; rx_byte = v; cyc(); rx_byte_valid = 1'b0;
    endtask
    task automatic load_tx(input logic [31:0] w);
        tx_load = 1'b1; tx_word = w; cyc(); tx_load = 1'b0;
    endtask
    task automatic take_tx();
        tx_take = 1'b1; cyc(); tx_take = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1; rst_n = 1'b1;
        cyc();
        cur_tag = "R1";
        chk(rx_done == 0 && tx_empty == 0 && tx_byte_valid == 0 && rx_word == 0,
            "R1", "reset outputs", {rx_word[28:0], rx_done, tx_empty, tx_byte_valid}, 0);

        cur_tag = "R2"; rx_word_en = 1;
        send_rx(8'h11); send_rx(8'h22); send_rx(8'h33);
        chk(rx_done == 0, "R2", "done early", 32'(rx_done), 0);
        send_rx(8'h44);
        chk(rx_done == 1 && rx_word == 32'h44332211, "R2", "word", rx_word, 32'h44332211);
        cyc();
        chk(rx_done == 0, "R2", "single pulse", 32'(rx_done), 0);

        cur_tag = "R3"; rx_word_en = 0;
        send_rx(8'hA5);
        chk(rx_done == 1 && rx_word == 32'h000000A5, "R3", "byte mode", rx_word, 32'hA5);
        send_rx(8'h3C);
        chk(rx_done == 1 && rx_word == 32'h0000003C, "R3", "byte mode 2", rx_word, 32'h3C);

        cur_tag = "R4"; char_size = 4'd7;
        send_rx(8'hFF);
        chk(rx_word == 32'h7F, "R4", "7-bit byte mode", rx_word, 32'h7F);
        char_size = 4'd5; rx_word_en = 1;
        repeat (4) send_rx(8'hFF);
        chk(rx_word == 32'h1F1F1F1F, "R4", "5-bit lanes", rx_word, 32'h1F1F1F1F);
        char_size = 4'd0;
        repeat (4) send_rx(8'hF0);
        chk(rx_word == 32'hF0F0F0F0, "R4", "size 0 means 8", rx_word, 32'hF0F0F0F0);
        char_size = 4'd8;

        cur_tag = "R11";
        send_rx(8'h01); send_rx(8'h02); send_rx(8'h03);
        repeat (4) begin
            cyc();
            chk(rx_done == 0, "R11", "partial held", 32'(rx_done), 0);
        end
        send_rx(8'h04);
        chk(rx_done == 1 && rx_word == 32'h04030201, "R11", "realign", rx_word, 32'h04030201);

        cur_tag = "R8"; len_total = 8'd6; len_sel = 2'd1; cyc();
        for (int i = 1; i <= 6; i++) send_rx(8'(i));
        chk(rx_done == 1 && rx_word == 32'h00000605, "R8", "short final word", rx_word, 32'h605);
        cur_tag = "R10";
        for (int i = 7; i <= 12; i++) send_rx(8'(i));
        chk(rx_done == 1 && rx_word == 32'h00000C0B, "R10", "second frame", rx_word, 32'hC0B);
        len_total = 8'd3; cyc();
        send_rx(8'hA1); send_rx(8'hA2);
        len_sel = 2'd0; cyc(); len_sel = 2'd1;
        send_rx(8'hA3);
        chk(rx_done == 0, "R10", "count restarted by off", 32'(rx_done), 0);
        send_rx(8'hA4);
        chk(rx_done == 1 && rx_word == 32'hA4A3A2A1, "R10", "full word", rx_word, 32'hA4A3A2A1);
        send_rx(8'hA5);
        chk(rx_done == 1 && rx_word == 32'h000000A5, "R10", "frame end", rx_word, 32'hA5);

        cur_tag = "R12"; len_total = 8'd2; tx_word_en = 1;
        load_tx(32'h0D0C0B0A);
        take_tx(); take_tx();
        chk(tx_empty == 0 && tx_byte_valid == 1, "R12", "rx count not on tx", 32'(tx_empty), 0);
        take_tx(); take_tx();
        chk(tx_empty == 1, "R12", "tx full word", 32'(tx_empty), 1);
        len_sel = 2'd2; cyc();
        send_rx(8'h51); send_rx(8'h52);
        chk(rx_done == 0, "R12", "tx count not on rx", 32'(rx_done), 0);
        send_rx(8'h53); send_rx(8'h54);
        chk(rx_word == 32'h54535251, "R12", "rx word", rx_word, 32'h54535251);
        len_sel = 2'd0; cyc();

        cur_tag = "R5"; load_tx(32'hDDCCBBAA);
        chk(tx_byte == 8'hAA, "R5", "lane 0", 32'(tx_byte), 32'hAA); take_tx();
        chk(tx_byte == 8'hBB, "R5", "lane 1", 32'(tx_byte), 32'hBB); take_tx();
        chk(tx_byte == 8'hCC, "R5", "lane 2", 32'(tx_byte), 32'hCC); take_tx();
        chk(tx_byte == 8'hDD, "R5", "lane 3", 32'(tx_byte), 32'hDD); take_tx();
        chk(tx_empty == 1 && tx_byte_valid == 0, "R5", "empty", 32'(tx_empty), 1);

        cur_tag = "R6"; tx_word_en = 0; load_tx(32'h12345678);
        chk(tx_byte == 8'h78, "R6", "byte mode lane", 32'(tx_byte), 32'h78); take_tx();
        chk(tx_empty == 1 && tx_byte_valid == 0, "R6", "empty after one", 32'(tx_empty), 1);

        cur_tag = "R7"; tx_word_en = 1; char_size = 4'd6; load_tx(32'hFFFFFFFF);
        chk(tx_byte == 8'h3F, "R7", "6-bit tx", 32'(tx_byte), 32'h3F);
        repeat (4) take_tx();
        char_size = 4'd8;

        cur_tag = "R9"; len_total = 8'd5; len_sel = 2'd2; cyc();
        load_tx(32'h44332211); repeat (4) take_tx();
        chk(tx_empty == 1, "R9", "first word", 32'(tx_empty), 1);
        load_tx(32'h88776655);
        chk(tx_byte == 8'h55, "R9", "last byte", 32'(tx_byte), 32'h55); take_tx();
        chk(tx_empty == 1 && tx_byte_valid == 0, "R9", "short end", 32'(tx_byte_valid), 0);
        len_sel = 2'd0; cyc();

        cur_tag = "R13"; load_tx(32'hA3A2A1A0); take_tx();
        load_tx(32'hB3B2B1B0);
        chk(tx_byte == 8'hA1, "R13", "load ignored", 32'(tx_byte), 32'hA1);
        repeat (3) take_tx();
        chk(tx_empty == 1, "R13", "old word drained", 32'(tx_empty), 1);
        repeat (2) cyc();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog timeout actual 1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule